// File: doc/BRIEF.md
# Strict-Priority Deficit Round Robin Scheduler with Length Compensation

This block selects one child queue at a time to feed a single parent flow. Every child node carries a 3-bit priority. Among the backlogged nodes, those with the lowest priority number are served before all others. Nodes that share a priority level split the bandwidth by deficit round robin. Each level keeps its own round-robin pointer, so a level that is preempted by higher-priority traffic resumes at the node where it stopped.

Each node is configured with four items:
- a 10-bit weight;
- a credit-unit bit, which selects byte or packet accounting;
- a 2-bit length mode, which sets how the head-of-line packet length is charged;
- its priority.

A global flat-mode input collapses all nodes onto one level, which gives plain weighted round robin. The block takes one decision per clock from the per-node backlog flags and head-of-line lengths. It then reports the served node through a registered dequeue strobe. The surrounding queue logic pops the packet before the next decision.

Top module: `sdrr_sched`

## Requirements
- R1: After reset `deq_valid` is 0, `deq_node` is 0, every deficit is 0 and every level pointer is 0.
- R2: A strobe only names a node whose priority number is the lowest among the backlogged nodes in the decision cycle. A newly backlogged lower-number node takes over at the next decision.
- R3: In byte mode (credit-unit bit 0), a level that cannot serve its pointer node first moves the pointer to the next backlogged node of that level, searching upward and wrapping. That node's deficit then grows by weight × `QUANTUM`, and no strobe is given in that cycle. A weight must be non-zero for a backlogged node.
- R4: In packet mode (credit-unit bit 1), each service costs 1 and each pointer arrival credits the weight.
- R5: The charged length depends on the length mode:
  - mode 0 charges the head length plus 20;
  - modes 1 and 3 charge the head length;
  - mode 2 charges the head length minus 18, floored at 0.
- R6: When `cfg_flat` is 1, all priorities are treated as 0 and all backlogged nodes share one round robin.
- R7: A node whose backlog flag is 0 at a clock edge has its deficit set to 0 by that edge.
- R8: Each of the 8 levels keeps its own pointer. A level that is preempted resumes from its stored pointer.
- R9: When the pointer node of the top level is backlogged and its deficit is at least its charge, it is served. The strobe appears on the next edge and the charge is taken from the node's deficit. With no backlogged node there is no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_flat | input | 1 | 1: ignore priorities, one round robin over all nodes |
| cfg_prio | input | NUM_NODES*PRIO_W | Per-node priority, 0 served first |
| cfg_weight | input | NUM_NODES*WEIGHT_W | Per-node DRR weight, non-zero |
| cfg_unit_pkt | input | NUM_NODES | Per-node credit unit: 1 packets, 0 bytes |
| cfg_len_mode | input | NUM_NODES*2 | Per-node charged-length mode |
| node_busy | input | NUM_NODES | Per-node backlog flag |
| head_len | input | NUM_NODES*LEN_W | Per-node head-of-line packet length in bytes |
| deq_valid | output | 1 | Dequeue strobe, one cycle per served packet |
| deq_node | output | NODE_W | Index of the served node |

## Verification
The bench replays long queue drains against an arithmetic model, cycle by cycle. This catches a design that credits a node without skipping a cycle, or that credits the wrong node after the wrap of the pointer search. It also catches a design that keeps stale deficit across an empty period, which would let a node burst too early. Packet-mode sweeps expose a design that charges bytes instead of 1. Short payload-mode packets expose a subtraction that wraps around instead of flooring at 0, which would starve that node. A high-priority burst injected mid-drain shows whether preemption happens at the very next decision. The same burst shows whether the lower level resumes at its own stored pointer or restarts at a shared pointer. A flat-mode pass shows whether priorities are really ignored.

// File: rtl/sdrr_pkg.sv
package sdrr_pkg;

   typedef enum logic [1:0] {
      LM_WIRE    = 2'd0,
      LM_FRAME   = 2'd1,
      LM_PAYLOAD = 2'd2,
      LM_RSVD    = 2'd3
   } len_mode_e;

   // inter-packet gap plus preamble bytes added in wire mode
   localparam int WIRE_EXTRA = 20;
   // layer-2 header plus CRC bytes removed in payload mode
   localparam int HDR_CRC = 18;

endpackage

// File: rtl/sdrr_len_comp.sv
module sdrr_len_comp
   import sdrr_pkg::*;
#(
   parameter int LEN_W  = 14,
   parameter int COST_W = LEN_W + 1
) (
   input  logic [LEN_W-1:0]  len,
   input  logic [1:0]        mode,
   input  logic              unit_pkt,
   output logic [COST_W-1:0] cost
);

   logic [COST_W-1:0] byte_cost;

   always_comb begin
      case (len_mode_e'(mode))
         LM_WIRE:    byte_cost = COST_W'(len) + COST_W'(WIRE_EXTRA);
         LM_PAYLOAD: byte_cost = (COST_W'(len) > COST_W'(HDR_CRC)) ?
                                 COST_W'(len) - COST_W'(HDR_CRC) : '0;
         default:    byte_cost = COST_W'(len);
      endcase
      cost = unit_pkt ? COST_W'(1) : byte_cost;
   end

endmodule

// File: rtl/sdrr_level_pick.sv
module sdrr_level_pick #(
   parameter int NUM_NODES = 8,
   parameter int PRIO_W    = 3,
   localparam int LEVELS   = 1 << PRIO_W
) (
   input  logic [NUM_NODES*PRIO_W-1:0] eprio,
   input  logic [NUM_NODES-1:0]        busy,
   output logic                        any_busy,
   output logic [PRIO_W-1:0]           top_lvl,
   output logic [NUM_NODES-1:0]        act_mask
);

   logic [NUM_NODES-1:0] lvl_mask [LEVELS];
   logic [LEVELS-1:0]    lvl_any;

   for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      for (genvar i = 0; i < NUM_NODES; i++) begin : g_node
         assign lvl_mask[l][i] = busy[i] &&
                                 (eprio[i*PRIO_W +: PRIO_W] == PRIO_W'(l));
      end
      assign lvl_any[l] = |lvl_mask[l];
   end

   always_comb begin
      top_lvl = '0;
      for (int l = LEVELS - 1; l >= 0; l--) begin
         if (lvl_any[l]) top_lvl = PRIO_W'(l);
      end
   end

   assign any_busy = |lvl_any;
   assign act_mask = lvl_mask[top_lvl];

endmodule

// File: rtl/sdrr_rr_next.sv
module sdrr_rr_next #(
   parameter int NUM_NODES = 8,
   localparam int NODE_W   = $clog2(NUM_NODES)
) (
   input  logic [NUM_NODES-1:0] mask,
   input  logic [NODE_W-1:0]    cur,
   output logic [NODE_W-1:0]    nxt
);

   // search cur+1 upward with wrap; cur itself is checked last
   always_comb begin
      nxt = cur;
      for (int k = NUM_NODES; k >= 1; k--) begin
         if (mask[(int'(cur) + k) % NUM_NODES])
            nxt = NODE_W'((int'(cur) + k) % NUM_NODES);
      end
   end

endmodule

// File: rtl/sdrr_sched.sv
module sdrr_sched
   import sdrr_pkg::*;
#(
   parameter int NUM_NODES = 8,
   parameter int PRIO_W    = 3,
   parameter int WEIGHT_W  = 10,
   parameter int LEN_W     = 14,
   parameter int QUANTUM   = 64,
   localparam int NODE_W   = $clog2(NUM_NODES),
   localparam int LEVELS   = 1 << PRIO_W,
   localparam int COST_W   = LEN_W + 1,
   localparam int QUANT_W  = $clog2(QUANTUM + 1),
   localparam int DEF_W    = WEIGHT_W + QUANT_W + 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_flat,
   input  logic [NUM_NODES*PRIO_W-1:0]   cfg_prio,
   input  logic [NUM_NODES*WEIGHT_W-1:0] cfg_weight,
   input  logic [NUM_NODES-1:0]          cfg_unit_pkt,
   input  logic [NUM_NODES*2-1:0]        cfg_len_mode,
   input  logic [NUM_NODES-1:0]          node_busy,
   input  logic [NUM_NODES*LEN_W-1:0]    head_len,
   output logic                          deq_valid,
   output logic [NODE_W-1:0]             deq_node
);

   if (NUM_NODES < 2) begin : g_bad_nodes
      $error("sdrr_sched: NUM_NODES must be at least 2");
   end
   if (QUANTUM < 1) begin : g_bad_quantum
      $error("sdrr_sched: QUANTUM must be positive");
   end
   if (COST_W > DEF_W) begin : g_bad_width
      $error("sdrr_sched: deficit narrower than charged length");
   end

   logic [NUM_NODES*PRIO_W-1:0] eprio_flat;
   logic [PRIO_W-1:0]           eprio  [NUM_NODES];
   logic [COST_W-1:0]           cost   [NUM_NODES];
   logic [DEF_W-1:0]            credit [NUM_NODES];
   logic [DEF_W-1:0]            deficit[NUM_NODES];
   logic [NODE_W-1:0]           rr_ptr [LEVELS];

   for (genvar i = 0; i < NUM_NODES; i++) begin : g_node
      logic [WEIGHT_W-1:0] wt;
      assign wt       = cfg_weight[i*WEIGHT_W +: WEIGHT_W];
      assign eprio[i] = cfg_flat ? '0 : cfg_prio[i*PRIO_W +: PRIO_W];
      assign eprio_flat[i*PRIO_W +: PRIO_W] = eprio[i];
      assign credit[i] = cfg_unit_pkt[i] ? DEF_W'(wt)
                                         : DEF_W'(wt) * DEF_W'(QUANTUM);

      sdrr_len_comp #(.LEN_W(LEN_W), .COST_W(COST_W)) u_len (
         .len      (head_len[i*LEN_W +: LEN_W]),
         .mode     (cfg_len_mode[i*2 +: 2]),
         .unit_pkt (cfg_unit_pkt[i]),
         .cost     (cost[i])
      );
   end

   logic                 any_busy;
   logic [PRIO_W-1:0]    top_lvl;
   logic [NUM_NODES-1:0] act_mask;

   sdrr_level_pick #(.NUM_NODES(NUM_NODES), .PRIO_W(PRIO_W)) u_pick (
      .eprio    (eprio_flat),
      .busy     (node_busy),
      .any_busy (any_busy),
      .top_lvl  (top_lvl),
      .act_mask (act_mask)
   );

   logic [NODE_W-1:0] cur;
   logic [NODE_W-1:0] nxt;
   assign cur = rr_ptr[top_lvl];

   sdrr_rr_next #(.NUM_NODES(NUM_NODES)) u_rr (
      .mask (act_mask),
      .cur  (cur),
      .nxt  (nxt)
   );

   logic           can_serve;
   logic [DEF_W:0] sum_w;
   logic [DEF_W-1:0] topped;

   assign can_serve = act_mask[cur] && (deficit[cur] >= DEF_W'(cost[cur]));
   assign sum_w     = {1'b0, deficit[nxt]} + {1'b0, credit[nxt]};
   assign topped    = sum_w[DEF_W] ? '1 : sum_w[DEF_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         deq_valid <= 1'b0;
         deq_node  <= '0;
         for (int l = 0; l < LEVELS; l++) rr_ptr[l] <= '0;
         for (int i = 0; i < NUM_NODES; i++) deficit[i] <= '0;
      end else begin
         deq_valid <= 1'b0;
         if (any_busy) begin
            if (can_serve) begin
               deq_valid    <= 1'b1;
               deq_node     <= cur;
               deficit[cur] <= deficit[cur] - DEF_W'(cost[cur]);
            end else begin
               rr_ptr[top_lvl] <= nxt;
               deficit[nxt]    <= topped;
            end
         end
         for (int i = 0; i < NUM_NODES; i++) begin
            if (!node_busy[i]) deficit[i] <= '0;
         end
      end
   end

   // ---------------- checks ----------------
   logic [PRIO_W-1:0]    chk_min;
   logic [PRIO_W-1:0]    chk_min_q;
   logic [PRIO_W-1:0]    chk_sel_q;
   logic [NUM_NODES-1:0] chk_busy_q;

   always_comb begin
      chk_min = '1;
      for (int i = 0; i < NUM_NODES; i++) begin
         if (node_busy[i] && (eprio[i] < chk_min)) chk_min = eprio[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_min_q  <= '0;
         chk_sel_q  <= '0;
         chk_busy_q <= '0;
      end else begin
         chk_min_q  <= chk_min;
         chk_sel_q  <= eprio[cur];
         chk_busy_q <= node_busy;
      end
   end

   AST_TOP_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
      deq_valid |-> (chk_sel_q == chk_min_q)); // R2

   AST_STROBE_BACKLOGGED: assert property (@(posedge clk) disable iff (!rst_n)
      deq_valid |-> chk_busy_q[deq_node]); // R9

   for (genvar i = 0; i < NUM_NODES; i++) begin : g_chk
      AST_EMPTY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
         !node_busy[i] |=> (deficit[i] == '0)); // R7

      AST_WEIGHT_NZ: assert property (@(posedge clk) disable iff (!rst_n)
         node_busy[i] |-> (cfg_weight[i*WEIGHT_W +: WEIGHT_W] != '0)); // R3
   end

endmodule

// File: tb/sdrr_sched_tb.sv
module sdrr_sched_tb;

   localparam int N  = 4;
   localparam int PW = 3;
   localparam int WW = 10;
   localparam int LW = 11;
   localparam int Q  = 32;
   localparam int NW = 2;
   localparam int QD = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_flat = 1'b0;
   logic [N*PW-1:0] cfg_prio = '0;
   logic [N*WW-1:0] cfg_weight = '0;
   logic [N-1:0]    cfg_unit_pkt = '0;
   logic [N*2-1:0]  cfg_len_mode = '0;
   logic [N-1:0]    node_busy = '0;
   logic [N*LW-1:0] head_len = '0;
   logic            deq_valid;
   logic [NW-1:0]   deq_node;

   always #4 clk = ~clk;

   sdrr_sched #(.NUM_NODES(N), .PRIO_W(PW), .WEIGHT_W(WW), .LEN_W(LW),
                .QUANTUM(Q)) u_dut (
      .clk (clk), .rst_n (rst_n), .cfg_flat (cfg_flat), .cfg_prio (cfg_prio),
      .cfg_weight (cfg_weight), .cfg_unit_pkt (cfg_unit_pkt),
      .cfg_len_mode (cfg_len_mode), .node_busy (node_busy),
      .head_len (head_len), .deq_valid (deq_valid), .deq_node (deq_node)
   );

   int total = 0;
   int bad = 0;
   bit done = 0;

   // bench model state
   int m_def [N];
   int m_ptr [8];
   int q [N][QD];
   int qh [N];
   int qt [N];
   int c_prio [N];
   int c_wt [N];
   int c_pkt [N];
   int c_mode [N];
   int c_flat = 0;

   function automatic int charge(int i, int len);
      if (c_pkt[i] != 0) return 1;
      case (c_mode[i])
         0: return len + 20;
         2: return (len > 18) ? len - 18 : 0;
         default: return len;
      endcase
   endfunction

   function automatic int ep(int i);
      return (c_flat != 0) ? 0 : c_prio[i];
   endfunction

   task automatic cfg_node(int i, int pr, int wt, int pkt, int mode);
      c_prio[i] = pr; c_wt[i] = wt; c_pkt[i] = pkt; c_mode[i] = mode;
      cfg_prio[i*PW +: PW]     = PW'(pr);
      cfg_weight[i*WW +: WW]   = WW'(wt);
      cfg_unit_pkt[i]          = pkt[0];
      cfg_len_mode[i*2 +: 2]   = mode[1:0];
   endtask

   task automatic push(int i, int len);
      q[i][qt[i] % QD] = len;
      qt[i]++;
   endtask

   function automatic bit any_q();
      for (int i = 0; i < N; i++) if (qt[i] != qh[i]) return 1;
      return 0;
   endfunction

   task automatic check(string tag, bit ok, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // one cycle: drive, model, clock, compare, pop
   task automatic step(string tag);
      int top, cur, nxt, ev, en;
      bit found;
      for (int i = 0; i < N; i++) begin
         node_busy[i] = (qt[i] != qh[i]);
         head_len[i*LW +: LW] = node_busy[i] ? LW'(q[i][qh[i] % QD]) : '0;
      end
      top = 99; ev = 0; en = 0;
      for (int i = 0; i < N; i++)
         if (node_busy[i] && ep(i) < top) top = ep(i);
      if (top != 99) begin
         cur = m_ptr[top];
         if (node_busy[cur] && ep(cur) == top &&
             m_def[cur] >= charge(cur, q[cur][qh[cur] % QD])) begin
            ev = 1; en = cur;
            m_def[cur] -= charge(cur, q[cur][qh[cur] % QD]);
         end else begin
            nxt = cur; found = 0;
            for (int k = 1; k <= N; k++) begin
               if (!found && node_busy[(cur+k)%N] && ep((cur+k)%N) == top) begin
                  nxt = (cur+k)%N; found = 1;
               end
            end
            m_ptr[top] = nxt;
            m_def[nxt] += (c_pkt[nxt] != 0) ? c_wt[nxt] : c_wt[nxt] * Q;
         end
      end
      for (int i = 0; i < N; i++) if (!node_busy[i]) m_def[i] = 0;
      @(negedge clk);
      check({tag, " strobe"}, deq_valid == ev[0], int'(deq_valid), ev);
      if (ev != 0) begin
         check({tag, " node"}, int'(deq_node) == en, int'(deq_node), en);
         qh[en]++;
      end
   endtask

   task automatic drain(string tag, int inj_at, int inj_node, int inj_cnt);
      int cyc = 0;
      while ((any_q() || cyc <= inj_at) && cyc < 6000 && !done) begin
         if (cyc == inj_at)
            for (int k = 0; k < inj_cnt; k++) push(inj_node, 60 + 13*k);
         step(tag);
         cyc++;
      end
      for (int k = 0; k < 3; k++) step(tag);
   endtask

   int cycles = 0;
   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1;
         bad++; total++;
         $display("FAIL R9 watchdog actual=%0d expected=%0d", cycles, 150000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         m_def[i] = 0; qh[i] = 0; qt[i] = 0;
         cfg_node(i, 0, 1, 0, 1);
      end
      for (int l = 0; l < 8; l++) m_ptr[l] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: idle after reset
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check("R1 reset strobe", deq_valid == 1'b0, int'(deq_valid), 0);
         check("R1 reset node", deq_node == '0, int'(deq_node), 0);
      end

      // R3, R7, R9: byte mode sweeps over weight sets, one level
      for (int s = 0; s < 4; s++) begin
         for (int i = 0; i < N; i++) cfg_node(i, 0, 1 + ((s + i) % 4), 0, 1);
         for (int i = 0; i < N; i++)
            for (int k = 0; k < 8; k++) push(i, 40 + ((i*37 + k*53 + s*29) % 300));
         drain("R3,R7,R9 byte", -1, 0, 0);
      end

      // R4: packet mode
      for (int s = 0; s < 3; s++) begin
         for (int i = 0; i < N; i++) cfg_node(i, 2, 1 + ((s*3 + i) % 4), 1, i % 3);
         for (int i = 0; i < N; i++)
            for (int k = 0; k < 10; k++) push(i, 64 + 100*k);
         drain("R4 packet", -1, 0, 0);
      end

      // R5: every length mode, payload floor with short packets
      for (int i = 0; i < N; i++) cfg_node(i, 1, 1, 0, i);
      for (int i = 0; i < N; i++)
         for (int k = 0; k < 8; k++) push(i, (k % 2 == 0) ? 10 + k : 15 + 7*k);
      drain("R5 lenmode", -1, 0, 0);

      // R2, R8: distinct levels with a mid-drain high-priority burst
      cfg_node(0, 0, 1, 0, 1);
      cfg_node(1, 4, 2, 0, 1);
      cfg_node(2, 4, 1, 0, 1);
      cfg_node(3, 6, 1, 0, 1);
      for (int i = 1; i < N; i++)
         for (int k = 0; k < 8; k++) push(i, 50 + ((i*41 + k*23) % 120));
      drain("R2,R8 prio", 9, 0, 3);

      // R6: same priorities, flat mode
      c_flat = 1; cfg_flat = 1'b1;
      for (int i = 0; i < N; i++)
         for (int k = 0; k < 6; k++) push(i, 30 + ((i*19 + k*31) % 90));
      drain("R6 flat", -1, 0, 0);

      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule